// File: doc/BRIEF.md
# Windowed Write-Once Watchdog Timer

This block is a watchdog peripheral for a system-on-chip. A 12-bit down-counter is advanced by a tick taken from a slow clock. The slow clock arrives as a one-cycle enable pulse in the system clock domain, and a fixed divide-by-128 prescaler turns those pulses into the counting tick. Software configures the watchdog through a mode register, and that register accepts one write after each reset. The mode register sets the reload value, the window bound, whether a timeout resets the system, whether a debugger halt freezes counting, and whether the watchdog is off entirely.

To keep the system alive, software writes a keyed restart command before the counter runs out. A restart with the correct key is honoured only while the counter is at or below the window bound. A restart that comes too early is treated as a fault.

When the counter underflows, or when a restart comes too early, the block raises sticky status flags. If reset is enabled, it also emits a fixed-width reset request pulse toward the system reset generator. The flags clear when the status register is read.

Top module: `wdog_window_timer`

## Requirements
- R1: After the counter is loaded with value V, and with `slow_en` high on every cycle, the VALUE register (address 3, bits [11:0]) reads V - floor(m/128). Here m is the number of clock edges since the load, and the reading holds as long as no underflow has occurred.
- R2: A tick that arrives while the counter is 0 reloads the reload value and sets the underflow flag (STATUS bit 0). The timeout is therefore reload+1 ticks.
- R3: `wdt_rst` goes high on the cycle after an underflow or an early restart, provided reset enable (MODE bit 12) is 1. It then stays high for exactly RST_CYCLES cycles (default 8). It never rises otherwise.
- R4: The MODE register sits at address 1. Its fields are reload [11:0], reset enable bit 12, debug-halt enable bit 13, disable bit 15 and window [27:16]. Only the first write after reset is accepted, and that write also loads the counter and clears the prescaler. Later writes are ignored.
- R5: A write to CTRL (address 0) with bit 0 set and bits [31:24] equal to 0xA5 is a restart. A restart inside the window reloads the counter and clears the prescaler. A write with any other key has no effect.
- R6: A keyed restart while the counter is above the window sets the error flag (STATUS bit 1) and does not reload the counter. A window of 0xFFF never produces this error.
- R7: While the disable bit is set, the counter holds its value, restarts are ignored, and no flag is set and no reset pulse is produced.
- R8: While debug-halt enable is 1 and `dbg_req` is high, the prescaler and the counter hold their values.
- R9: A read of STATUS (address 2) returns the flags and clears them. If an event arrives in the same cycle as the read, the read returns the old value and the flag stays set.
- R10: After reset, MODE reads 0x0FFF1FFF (reload 0xFFF, window 0xFFF, reset enabled), STATUS reads 0, VALUE reads 0xFFF and `wdt_rst` is low. Read data appears on `rdata` one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_en | input | 1 | One-cycle pulse per slow-clock period |
| dbg_req | input | 1 | Debugger halt request |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| wdt_rst | output | 1 | Reset request pulse |

## Verification
The two functions that can meet in one cycle are the underflow, which sets a status flag, and the status read, which clears the flags. The bench provokes the collision by counting cycles from the mode write, so that the STATUS read is captured on exactly the edge where the underflow tick lands. It judges the result from three observations: the colliding read must return 0, the next read must return the underflow flag, and the read after that must return 0. A second meeting point is a keyed restart arriving on a tick edge. The window scenario covers it: after an early restart the counter must not be reloaded, while a restart inside the window must bring VALUE back to the reload value.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int CNT_W   = 12;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int KEY_W   = 8;
    localparam logic [KEY_W-1:0] RESTART_KEY = 8'hA5;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MODE  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_VALUE = 2'd3;

    localparam int RSTEN_BIT = 12;
    localparam int HALT_BIT  = 13;
    localparam int DIS_BIT   = 15;
    localparam int WIN_LSB   = 16;
    localparam int KEY_LSB   = DATA_W - KEY_W;

    typedef struct packed {
        logic             dis;
        logic             dbg_halt;
        logic             rst_en;
        logic [CNT_W-1:0] window;
        logic [CNT_W-1:0] reload;
    } mode_t;

    localparam mode_t DEFAULT_MODE = '{dis: 1'b0, dbg_halt: 1'b0, rst_en: 1'b1,
                                       window: '1, reload: '1};

    function automatic mode_t unpack_mode(input logic [DATA_W-1:0] w);
        mode_t m;
        m.reload   = w[CNT_W-1:0];
        m.window   = w[WIN_LSB +: CNT_W];
        m.rst_en   = w[RSTEN_BIT];
        m.dbg_halt = w[HALT_BIT];
        m.dis      = w[DIS_BIT];
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] pack_mode(input mode_t m);
        logic [DATA_W-1:0] w;
        w                    = '0;
        w[CNT_W-1:0]         = m.reload;
        w[WIN_LSB +: CNT_W]  = m.window;
        w[RSTEN_BIT]         = m.rst_en;
        w[HALT_BIT]          = m.dbg_halt;
        w[DIS_BIT]           = m.dis;
        return w;
    endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_en,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (run && slow_en) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                tick     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  mode_t            mode,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt,
    output logic             reload_ok,
    output logic             uf_evt,
    output logic             err_evt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       active;

    assign active    = !mode.dis && !load;
    assign reload_ok = active && restart && (st_q.cnt <= mode.window);
    assign err_evt   = active && restart && (st_q.cnt > mode.window);
    assign cnt       = st_q.cnt;

    always_comb begin
        st_d   = st_q;
        uf_evt = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
        end else if (reload_ok) begin
            st_d.cnt = mode.reload;
        end else if (active && tick) begin
            if (st_q.cnt == '0) begin
                uf_evt   = 1'b1;
                st_d.cnt = mode.reload;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.cnt <= DEFAULT_MODE.reload;
        else        st_q     <= st_d;
    end
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    localparam int RW = $clog2(CYCLES + 1);
    localparam logic [RW-1:0] FULL = RW'(CYCLES);

    typedef struct packed {
        logic [RW-1:0] left;
    } gen_state_t;

    gen_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire)                st_d.left = FULL;
        else if (st_q.left != 0) st_d.left = st_q.left - 1'b1;
    end

    assign pulse = (st_q.left != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              uf_evt,
    input  logic              err_evt,
    output mode_t             mode,
    output logic              locked,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic              restart,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        mode_t             mode;
        logic              locked;
        logic              uf;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } reg_state_t;

    localparam reg_state_t RESET_STATE = '{mode: DEFAULT_MODE, locked: 1'b0,
                                           uf: 1'b0, err: 1'b0, rdata: '0};

    reg_state_t st_d, st_q;
    mode_t      wr_mode;
    logic       unused_bits;

    assign wr_mode     = unpack_mode(wdata);
    assign load_val    = wr_mode.reload;
    assign unused_bits = ^{wdata[KEY_LSB-1:1]};

    // Decode kept apart from the state update so that event inputs do not loop
    always_comb begin
        load    = wr_en && (addr == ADDR_MODE) && !st_q.locked;
        restart = wr_en && (addr == ADDR_CTRL) && wdata[0]
                  && (wdata[KEY_LSB +: KEY_W] == RESTART_KEY);
    end

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.mode   = wr_mode;
            st_d.locked = 1'b1;
        end
        if (rd_en) begin
            unique case (addr)
                ADDR_MODE:  st_d.rdata = pack_mode(st_q.mode);
                ADDR_STAT: begin
                    st_d.rdata = {{(DATA_W-2){1'b0}}, st_q.err, st_q.uf};
                    st_d.uf    = 1'b0;
                    st_d.err   = 1'b0;
                end
                ADDR_VALUE: st_d.rdata = {{(DATA_W-CNT_W){1'b0}}, cnt};
                default:    st_d.rdata = '0;
            endcase
        end
        if (uf_evt)  st_d.uf  = 1'b1;
        if (err_evt) st_d.err = 1'b1;
    end

    assign mode   = st_q.mode;
    assign locked = st_q.locked;
    assign rdata  = st_q.rdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdog_window_timer.sv
module wdog_window_timer
    import wdog_pkg::*;
#(
    parameter int PRE_DIV    = 128,
    parameter int RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_en,
    input  logic              dbg_req,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              wdt_rst
);
    mode_t            mode;
    logic             locked;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             restart;
    logic [CNT_W-1:0] cnt;
    logic             reload_ok;
    logic             uf_evt;
    logic             err_evt;
    logic             tick;
    logic             run;
    logic             pre_clear;
    logic             fire;

    assign run       = !mode.dis && !(mode.dbg_halt && dbg_req);
    assign pre_clear = load || reload_ok;
    assign fire      = (uf_evt || err_evt) && mode.rst_en;

    wdog_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .cnt(cnt), .uf_evt(uf_evt), .err_evt(err_evt),
        .mode(mode), .locked(locked), .load(load), .load_val(load_val),
        .restart(restart), .rdata(rdata)
    );

    wdog_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .run(run),
        .clear(pre_clear), .tick(tick)
    );

    wdog_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .load(load),
        .load_val(load_val), .restart(restart), .cnt(cnt),
        .reload_ok(reload_ok), .uf_evt(uf_evt), .err_evt(err_evt)
    );

    wdog_rstgen #(.CYCLES(RST_CYCLES)) u_rst (
        .clk(clk), .rst_n(rst_n), .fire(fire), .pulse(wdt_rst)
    );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
    import wdog_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             dbg_req,
    input logic             wdt_rst,
    input mode_t            mode,
    input logic             locked,
    input logic             load,
    input logic             restart,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic             uf_evt,
    input logic             err_evt
);
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> $stable(mode)); // R4

    AST_UF_RAISES_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_evt && mode.rst_en) |=> wdt_rst); // R3

    AST_RST_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst) |-> $past((uf_evt || err_evt) && mode.rst_en)); // R3

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mode.dis |-> (!uf_evt && !err_evt && !tick)); // R7

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.dbg_halt && dbg_req && !load && !restart) |=> $stable(cnt)); // R8

    AST_NO_TICK_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !restart && !tick) |=> $stable(cnt)); // R1

    AST_OPEN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.window == '1) |-> !err_evt); // R6
endmodule

bind wdog_window_timer wdog_checker u_chk (
    .clk(clk), .rst_n(rst_n), .dbg_req(dbg_req), .wdt_rst(wdt_rst),
    .mode(mode), .locked(locked), .load(load), .restart(restart),
    .tick(tick), .cnt(cnt), .uf_evt(uf_evt), .err_evt(err_evt)
);

// File: tb/test_wdog_window_timer.sv
module test_wdog_window_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_en = 1'b1;
    logic        dbg_req = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wdt_rst;

    int total = 0;
    int bad = 0;
    int rst_cnt = 0;
    int m = 0;
    logic [31:0] rd;
    bit done = 1'b0;

    wdog_window_timer i_wdog_window_timer (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .dbg_req(dbg_req),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wdt_rst(wdt_rst)
    );

    always #4 clk = ~clk;

    always @(posedge clk) if (rst_n && wdt_rst) rst_cnt <= rst_cnt + 1;

    function automatic logic [31:0] exp_value(input int reload, input int cycles);
        return 32'(reload - cycles / 128);
    endfunction

    function automatic logic [31:0] mode_word(input int reload, input int window,
                                              input bit ren, input bit halt, input bit dis);
        return 32'(reload) | (32'(window) << 16) | (32'(ren) << 12)
               | (32'(halt) << 13) | (32'(dis) << 15);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All bus tasks are entered right after a falling edge and return at one
    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        m++;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
        m++;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        m += n;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rst_cnt = 0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();

        // Reset state
        chk("R10 rst low", 32'(wdt_rst), 32'd0);
        bus_rd(2'd1, rd); chk("R10 mode reset", rd, 32'h0FFF1FFF);
        bus_rd(2'd2, rd); chk("R10 status reset", rd, 32'd0);
        bus_rd(2'd3, rd); chk("R10 value reset", rd, 32'h0000_0FFF);

        // Underflow with reset enabled, collision with status read
        do_reset();
        bus_wr(2'd1, mode_word(2, 12'hFFF, 1, 0, 0)); m = 0;
        idle(383);
        chk("R3 no rst before underflow", 32'(rst_cnt), 32'd0);
        bus_rd(2'd2, rd); chk("R9 read on underflow edge", rd, 32'd0);
        chk("R3 rst after underflow", 32'(wdt_rst), 32'd1);
        idle(20);
        bus_rd(2'd2, rd); chk("R9 flag survives collision", rd, 32'd1);
        bus_rd(2'd2, rd); chk("R9 flag cleared by read", rd, 32'd0);
        chk("R3 pulse width", 32'(rst_cnt), 32'd8);

        // Underflow without reset enable
        do_reset();
        bus_wr(2'd1, mode_word(1, 12'hFFF, 0, 0, 0)); m = 0;
        idle(300);
        bus_rd(2'd2, rd); chk("R2 underflow flag", rd, 32'd1);
        bus_rd(2'd3, rd); chk("R2 reload after underflow", rd, exp_value(1, m - 1 - 256));
        chk("R3 no rst when disabled enable", 32'(rst_cnt), 32'd0);

        // Window check
        do_reset();
        bus_wr(2'd1, mode_word(32, 16, 1, 0, 0)); m = 0;
        idle(1000);
        bus_wr(2'd0, 32'hA500_0001);
        chk("R6 early restart fires rst", 32'(wdt_rst), 32'd1);
        bus_rd(2'd2, rd); chk("R6 error flag", rd, 32'd2);
        bus_rd(2'd3, rd); chk("R6 no reload when early", rd, exp_value(32, m - 1));
        idle(2100 - m);
        bus_wr(2'd0, 32'h5A00_0001);
        bus_rd(2'd3, rd); chk("R5 wrong key ignored", rd, exp_value(32, m - 1));
        bus_wr(2'd0, 32'hA500_0001); m = 0;
        bus_rd(2'd2, rd); chk("R6 no error inside window", rd, 32'd0);
        bus_rd(2'd3, rd); chk("R5 restart reloads", rd, 32'd32);

        // Disable
        do_reset();
        bus_wr(2'd1, mode_word(7, 12'hFFF, 1, 0, 1));
        idle(2000);
        bus_wr(2'd0, 32'hA500_0001);
        bus_rd(2'd3, rd); chk("R7 counter held", rd, 32'd7);
        bus_rd(2'd2, rd); chk("R7 no flags", rd, 32'd0);
        chk("R7 no rst", 32'(rst_cnt), 32'd0);

        // Debug halt
        do_reset();
        dbg_req = 1'b1;
        bus_wr(2'd1, mode_word(5, 12'hFFF, 0, 1, 0));
        idle(1000);
        bus_rd(2'd3, rd); chk("R8 frozen during halt", rd, 32'd5);
        dbg_req = 1'b0; m = 0;
        idle(300);
        bus_rd(2'd3, rd); chk("R8 resumes after halt", rd, exp_value(5, 300));

        // Random restarts, keys and waits
        for (int it = 0; it < 4; it++) begin
            int wdv;
            logic [31:0] mw;
            do_reset();
            wdv = 8 + int'($urandom % 24);
            mw = mode_word(wdv, 12'hFFF, 0, 0, 0);
            bus_wr(2'd1, mw); m = 0;
            bus_wr(2'd1, 32'h0000_8003);
            bus_rd(2'd1, rd); chk("R4 second mode write ignored", rd, mw);
            for (int s = 0; s < 8; s++) begin
                int sel;
                int n;
                sel = int'($urandom % 3);
                n = int'($urandom % 300);
                if (m + n + 4 >= wdv * 128) sel = 1;
                if (sel == 0) begin
                    idle(n);
                end else if (sel == 1) begin
                    bus_wr(2'd0, 32'hA500_0001); m = 0;
                end else begin
                    logic [7:0] key;
                    key = 8'($urandom);
                    if (key == 8'hA5) key = 8'h00;
                    bus_wr(2'd0, {key, 23'd0, 1'b1});
                end
                bus_rd(2'd3, rd); chk("R1 R5 counter model", rd, exp_value(wdv, m - 1));
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule